// File: doc/BRIEF.md
# Compressed VLIW Instruction Expander

The expander turns a narrow 32-bit instruction word into a wide, four-slot instruction for parallel arithmetic units. Each slot owns two small local tables. One holds operand fields, which are register selections or immediates. The other holds operation codes. The incoming word does not carry the wide operation itself. It carries two table addresses, a per-slot enable mask and an immediate. A controlling processor fills the tables beforehand, so a recurring algorithm can run from short words alone.

Instructions enter through a valid/ready handshake and pass through three register stages:

- Decode: the operand table is read here.
- Substitution: the operand value is settled here, either from the table or from the immediate, and the opcode table is read.
- Output: the per-slot opcode and operand fields are presented here.

When the consumer is not ready, the whole pipeline stalls as one. A slot whose enable bit is clear receives a no-operation code and keeps its operand output unchanged, so its output wires do not toggle.

Top module: `vliw_expander`

## Requirements
- R1: After reset, out_valid is 0, every slot's opcode and operand output is 0, in_ready is 1, and every table entry reads as 0.
- R2: The instruction word is {bit 31 mode, bits 30:26 operand table address, bits 25:21 opcode table address, bits 20:17 slot enable mask (bit 17 is slot 0), bits 16:0 immediate}. out_mask presents the mask of the instruction being output.
- R3: For an enabled slot with mode 0, the slot's operand output is the entry of that slot's operand table at the operand address.
- R4: For an enabled slot with mode 1, the slot's operand output is immediate bits 15:0, and the operand table is not used.
- R5: For an enabled slot, the slot's opcode output is the entry of that slot's opcode table at the opcode address.
- R6: For a disabled slot, the opcode output is the no-operation code 0, and the operand output keeps the value it last had.
- R7: With out_ready held at 1, an instruction accepted on a rising edge appears with out_valid = 1 after the third rising edge, counting the accepting edge as the first.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and all outputs hold. In all other cases in_ready is 1. Instructions leave in the order they were accepted, each exactly once.
- R9: A table write (cfg_we with cfg_slot, cfg_is_opc = 1 for the opcode table and 0 for the operand table, cfg_addr, cfg_data) lands on the rising edge. It is seen by every instruction accepted on a later edge. The opcode table stores cfg_data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | 2 | Slot selected for the write |
| cfg_is_opc | input | 1 | 1 writes the opcode table, 0 writes the operand table |
| cfg_addr | input | 5 | Table entry to write |
| cfg_data | input | 16 | Write data |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Instruction word accepted this cycle |
| in_instr | input | 32 | Compressed instruction word |
| out_valid | output | 1 | Expanded instruction present |
| out_ready | input | 1 | Consumer takes the expanded instruction |
| out_mask | output | 4 | Slot enable mask of the output instruction |
| out_opc | output | 32 | Four 8-bit opcodes, slot 0 in bits 7:0 |
| out_opnd | output | 64 | Four 16-bit operands, slot 0 in bits 15:0 |

## Verification
The hardest case to reach from the ports is a disabled slot holding its operand. The held value must survive across stalls and bubbles, and it must still match whatever the slot last produced, possibly many instructions earlier. The stimulus therefore mixes random masks (including all-clear and all-set), random modes, bursty in_valid and long random stretches of out_ready low. The bench model tracks, per slot, the last operand value it expects. On top of this, a directed single-instruction run measures latency. Finally, table rewrites are made between drained bursts, and the instructions that follow address the rewritten entries.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int INSTR_W  = 32;
  localparam int N_SLOTS  = 4;
  localparam int TAB_AW   = 5;
  localparam int OPND_W   = 16;
  localparam int OPC_W    = 8;
  localparam int IMM_W    = 17;

  typedef struct packed {
    logic                mode;
    logic [TAB_AW-1:0]   opnd_addr;
    logic [TAB_AW-1:0]   opc_addr;
    logic [N_SLOTS-1:0]  en_mask;
    logic [IMM_W-1:0]    imm;
  } cinstr_t;

  localparam logic [OPC_W-1:0] OPC_NOP = '0;
endpackage

// File: rtl/vliw_cfg_table.sv
module vliw_cfg_table #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] entry_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (we) begin
      entry_q[waddr] <= wdata;
    end
  end

  assign rdata = entry_q[raddr];

  // R9: a written entry reads back its data on the next cycle when not rewritten
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we && (raddr == waddr) |=> (($past(raddr) != raddr) || ($past(we) && rdata == $past(wdata))
                                 || !$past(we)));
endmodule

// File: rtl/vliw_pipe_ctrl.sv
module vliw_pipe_ctrl
  import vliw_pkg::*;
#(
  parameter int NS = N_SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  cinstr_t       in_instr,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          adv,
  output logic          d_vld,
  output cinstr_t       d_instr,
  output logic          s_vld,
  output cinstr_t       s_instr,
  output logic          o_vld,
  output logic [NS-1:0] o_mask
);
  logic    d_vld_n, s_vld_n, o_vld_n;
  cinstr_t d_instr_n, s_instr_n;
  logic [NS-1:0] o_mask_n;

  assign adv      = !o_vld || out_ready;
  assign in_ready = adv;

  always_comb begin
    d_vld_n   = d_vld;
    s_vld_n   = s_vld;
    o_vld_n   = o_vld;
    d_instr_n = d_instr;
    s_instr_n = s_instr;
    o_mask_n  = o_mask;
    if (adv) begin
      d_vld_n = in_valid;
      s_vld_n = d_vld;
      o_vld_n = s_vld;
      if (in_valid) d_instr_n = in_instr;
      if (d_vld)    s_instr_n = d_instr;
      if (s_vld)    o_mask_n  = s_instr.en_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_vld   <= 1'b0;
      s_vld   <= 1'b0;
      o_vld   <= 1'b0;
      d_instr <= '0;
      s_instr <= '0;
      o_mask  <= '0;
    end else begin
      d_vld   <= d_vld_n;
      s_vld   <= s_vld_n;
      o_vld   <= o_vld_n;
      d_instr <= d_instr_n;
      s_instr <= s_instr_n;
      o_mask  <= o_mask_n;
    end
  end

  // R8: a stalled pipeline keeps every stage's occupancy
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({d_vld, s_vld, o_vld}) && $stable(s_instr));
  // R7: an accepted word occupies decode on the next cycle
  p_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && in_valid |=> d_vld && (d_instr == $past(in_instr)));
  // R7: a word in substitution reaches the output stage on advance
  p_reach_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s_vld |=> o_vld);
endmodule

// File: rtl/vliw_slot.sv
module vliw_slot
  import vliw_pkg::*;
#(
  parameter int AW  = TAB_AW,
  parameter int DW  = OPND_W,
  parameter int CW  = OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_opnd,
  input  logic          we_opc,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          adv,
  input  logic          d_vld,
  input  logic          d_en,
  input  logic          d_mode,
  input  logic [AW-1:0] d_opnd_addr,
  input  logic [DW-1:0] d_imm,
  input  logic          s_vld,
  input  logic          s_en,
  input  logic [AW-1:0] s_opc_addr,
  output logic [CW-1:0] opc_out,
  output logic [DW-1:0] opnd_out
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] opnd_rd;
  logic [CW-1:0] opc_rd;
  logic [DW-1:0] s_opnd, s_opnd_n, opnd_out_n;
  logic [CW-1:0] opc_out_n;
  logic          s_load, o_load;

  vliw_cfg_table #(.W(DW), .DEPTH(DEPTH), .AW(AW)) u_opnd_tab (
    .clk(clk), .rst_n(rst_n), .we(we_opnd), .waddr(wr_addr), .wdata(wr_data),
    .raddr(d_opnd_addr), .rdata(opnd_rd)
  );

  vliw_cfg_table #(.W(CW), .DEPTH(DEPTH), .AW(AW)) u_opc_tab (
    .clk(clk), .rst_n(rst_n), .we(we_opc), .waddr(wr_addr), .wdata(wr_data[CW-1:0]),
    .raddr(s_opc_addr), .rdata(opc_rd)
  );

  assign s_load = adv && d_vld && d_en;
  assign o_load = adv && s_vld;

  always_comb begin
    s_opnd_n   = s_opnd;
    opc_out_n  = opc_out;
    opnd_out_n = opnd_out;
    if (s_load) s_opnd_n = d_mode ? d_imm : opnd_rd;
    if (o_load) begin
      opc_out_n = s_en ? opc_rd : OPC_NOP;
      if (s_en) opnd_out_n = s_opnd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_opnd   <= '0;
      opc_out  <= '0;
      opnd_out <= '0;
    end else begin
      s_opnd   <= s_opnd_n;
      opc_out  <= opc_out_n;
      opnd_out <= opnd_out_n;
    end
  end

  // R6: a disabled slot emits the no-op code and keeps its operand
  p_idle_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    o_load && !s_en |=> (opc_out == OPC_NOP) && $stable(opnd_out));
  // R4: immediate mode carries the immediate into the substitution stage
  p_subst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_load && d_mode |=> s_opnd == $past(d_imm));
  // R8: no output change while stalled
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(opc_out) && $stable(opnd_out));
endmodule

// File: rtl/vliw_expander.sv
module vliw_expander
  import vliw_pkg::*;
#(
  parameter int NS  = N_SLOTS,
  parameter int AW  = TAB_AW,
  parameter int DW  = OPND_W,
  parameter int CW  = OPC_W,
  parameter int IW  = INSTR_W,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic             cfg_is_opc,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IW-1:0]    in_instr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NS-1:0]    out_mask,
  output logic [NS*CW-1:0] out_opc,
  output logic [NS*DW-1:0] out_opnd
);
  logic    adv, d_vld, s_vld;
  cinstr_t d_instr, s_instr;

  vliw_pipe_ctrl #(.NS(NS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(cinstr_t'(in_instr)),
    .out_ready(out_ready), .in_ready(in_ready), .adv(adv),
    .d_vld(d_vld), .d_instr(d_instr), .s_vld(s_vld), .s_instr(s_instr),
    .o_vld(out_valid), .o_mask(out_mask)
  );

  for (genvar g = 0; g < NS; g++) begin : g_slot
    logic sel;
    assign sel = cfg_we && (cfg_slot == SW'(g));
    vliw_slot #(.AW(AW), .DW(DW), .CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .we_opnd(sel && !cfg_is_opc), .we_opc(sel && cfg_is_opc),
      .wr_addr(cfg_addr), .wr_data(cfg_data),
      .adv(adv), .d_vld(d_vld), .d_en(d_instr.en_mask[g]), .d_mode(d_instr.mode),
      .d_opnd_addr(d_instr.opnd_addr), .d_imm(d_instr.imm[DW-1:0]),
      .s_vld(s_vld), .s_en(s_instr.en_mask[g]), .s_opc_addr(s_instr.opc_addr),
      .opc_out(out_opc[g*CW +: CW]), .opnd_out(out_opnd[g*DW +: DW])
    );
  end

  // R8: a refused output is held in full
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_opc)
                                && $stable(out_opnd));
  // R8: no acceptance while the output is refused
  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/vliw_expander_bench.sv
module vliw_expander_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_slot = 0;
  logic        cfg_is_opc = 0;
  logic [4:0]  cfg_addr = 0;
  logic [15:0] cfg_data = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_instr = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [3:0]  out_mask;
  logic [31:0] out_opc;
  logic [63:0] out_opnd;

  vliw_expander u_vliw_expander (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_is_opc(cfg_is_opc), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
    .out_opc(out_opc), .out_opnd(out_opnd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_opnd [4][32];
  logic [7:0]  m_opc  [4][32];
  logic [15:0] last_opnd [4];
  logic [31:0] pending [$];
  bit          stalled_prev = 0;
  logic [3:0]  snap_mask;
  logic [31:0] snap_opc;
  logic [63:0] snap_opnd;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int s, input bit opc, input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 2'(s); cfg_is_opc = opc; cfg_addr = 5'(a); cfg_data = d;
    if (opc) m_opc[s][a] = d[7:0]; else m_opnd[s][a] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Compare an output word against the model's front entry.
  task automatic consume();
    logic [31:0] w;
    logic [15:0] e_opnd;
    logic [7:0]  e_opc;
    if (pending.size() == 0) begin
      check(0, "R8", "output with nothing pending", 1, 0);
      return;
    end
    w = pending.pop_front();
    check(out_mask == w[20:17], "R2", "mask", out_mask, w[20:17]);
    for (int s = 0; s < 4; s++) begin
      if (w[17+s]) begin
        e_opc  = m_opc[s][w[25:21]];
        e_opnd = w[31] ? w[15:0] : m_opnd[s][w[30:26]];
        last_opnd[s] = e_opnd;
        check(out_opc[s*8 +: 8] == e_opc, "R5", "opcode", out_opc[s*8 +: 8], e_opc);
        check(out_opnd[s*16 +: 16] == e_opnd, w[31] ? "R4" : "R3", "operand",
              out_opnd[s*16 +: 16], e_opnd);
      end else begin
        check(out_opc[s*8 +: 8] == 8'h00, "R6", "nop opcode", out_opc[s*8 +: 8], 0);
        check(out_opnd[s*16 +: 16] == last_opnd[s], "R6", "held operand",
              out_opnd[s*16 +: 16], last_opnd[s]);
      end
    end
  endtask

  // One clock: drive at the falling edge, then evaluate outputs.
  task automatic cycle(input bit iv, input logic [31:0] ins, input bit ordy);
    @(negedge clk);
    in_valid = iv; in_instr = ins; out_ready = ordy;
    #1;
    if (stalled_prev) begin
      check(out_valid && out_mask == snap_mask && out_opc == snap_opc && out_opnd == snap_opnd,
            "R8", "stall hold", out_opnd, snap_opnd);
    end
    check(in_ready == (!out_valid || out_ready), "R8", "in_ready", in_ready,
          !out_valid || out_ready);
    stalled_prev = out_valid && !out_ready;
    snap_mask = out_mask; snap_opc = out_opc; snap_opnd = out_opnd;
    if (out_valid && out_ready) consume();
    if (in_valid && in_ready) pending.push_back(ins);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) cycle(0, 32'h0, 1);
    check(pending.size() == 0, "R8", "nothing lost", pending.size(), 0);
  endtask

  function automatic logic [31:0] mk(input bit md, input int oa, input int ca,
                                     input logic [3:0] mk_, input logic [16:0] im);
    return {md, 5'(oa), 5'(ca), mk_, im};
  endfunction

  initial begin
    repeat (10000 * CLK_PERIOD) #1;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      last_opnd[s] = 0;
      for (int a = 0; a < 32; a++) begin m_opnd[s][a] = 0; m_opc[s][a] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check(!out_valid && out_opc == 0 && out_opnd == 0, "R1", "outputs after reset",
          out_opnd, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    // R1: an unwritten table reads zero
    cycle(1, mk(0, 7, 9, 4'hF, 17'h0), 1);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1);

    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 32; a++) begin
        cfg_write(s, 0, a, 16'(s * 4099 + a * 263 + 17));
        cfg_write(s, 1, a, 16'(s * 61 + a * 7 + 3));
      end

    // R7: latency of a lone instruction
    cycle(1, mk(0, 3, 4, 4'hF, 17'h0), 1);
    cycle(0, 0, 1); check(!out_valid, "R7", "valid after 1 edge", out_valid, 0);
    cycle(0, 0, 1); check(!out_valid, "R7", "valid after 2 edges", out_valid, 0);
    cycle(0, 0, 1); check(out_valid, "R7", "valid after 3 edges", out_valid, 1);
    drain();

    // R4, R6: immediate mode, then masked slots hold the immediate
    cycle(1, mk(1, 0, 1, 4'hF, 17'h1ABCD), 1);
    cycle(1, mk(0, 5, 6, 4'h0, 17'h0), 1);
    cycle(1, mk(0, 8, 2, 4'h5, 17'h0), 1);
    drain();

    // R2..R8: random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] m;
      int r = $urandom_range(0, 9);
      m = (r == 0) ? 4'h0 : (r == 1) ? 4'hF : 4'($urandom);
      cycle($urandom_range(0, 3) != 0,
            mk(1'($urandom), $urandom_range(0, 31), $urandom_range(0, 31), m, 17'($urandom)),
            $urandom_range(0, 2) != 0);
    end
    drain();

    // R9: rewrites are seen by later instructions
    cfg_write(2, 0, 11, 16'hBEEF);
    cfg_write(2, 1, 30, 16'h00A5);
    cfg_write(0, 1, 11, 16'h005A);
    cycle(1, mk(0, 11, 30, 4'h4, 17'h0), 1);
    cycle(1, mk(0, 11, 11, 4'h1, 17'h0), 1);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule